// File: doc/BRIEF.md
# DDR1-to-DDR3 Command Bridge

This block sits between a host controller built for a DDR1 SDRAM and an attached DDR3 device, and makes the pair look like a DDR1 part to the host. The host side is a 16-bit double-rate slave port. The memory side is an 8-bit double-rate master port. The block runs on the memory clock, which is four times the host clock, and an internal phase counter marks the memory cycle in which host-side signals are sampled and updated. Double-rate data is modelled as two words per clock. On the host port each clock carries a two-word burst, and on the memory port each clock carries two bytes.

Host commands are forwarded one memory cycle after the host edge that samples them. The two host bank bits are widened to the three DDR3 bank bits with a zero MSB, so the upper four banks are never touched. A write burst of two 16-bit words leaves as four bytes, low byte first, placed at the DDR3 write latency. Read bytes return at the DDR3 read latency. They are joined back into 16-bit words and held in a pipeline, with no buffer memory, until the host read latency of three host cycles comes due. Refresh scheduling remains the host's job, and the bridge passes refresh commands through unchanged.

Top module: `ddr1_ddr3_bridge`

## Requirements
- R1: After reset, mem_cmd_o is NOP (0), mem_wvalid_o is 0 and host_rvalid_o is 0.
- R2: While init_done_i is low, no host command reaches the memory port, and mem_cmd_o stays NOP.
- R3: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5 on both ports. A host command sampled at a host edge (a clock edge with host_tick_o high) appears on mem_cmd_o for exactly the following memory cycle, with mem_addr_o equal to host_addr_i. Codes 6 and 7 are ignored and produce NOP.
- R4: mem_ba_o is {1'b0, host_ba_i}, so bank bit 2 is always 0.
- R5: For a WR command on mem_cmd_o in cycle k, mem_wvalid_o is high in cycles k+6 and k+7. The host write data is sampled at the next host edge after the command, with bits [15:0] as the first word. The first word goes out in cycle k+6 and the second in k+7. In each cycle bits [7:0] carry the low byte (first beat) and bits [15:8] the high byte.
- R6: host_wmask_i bit i masks byte i of the burst (1 = masked). mem_wmask_o follows the data split: bits [1:0] go out with the first word and bits [3:2] with the second, with bit 0 of each pair for the low byte.
- R7: For a RD on mem_cmd_o in cycle k, the memory bytes presented on mem_rdata_i in cycles k+8 and k+9 are captured. They appear on host_rdata_o ({second word, first word}) with host_rvalid_o high for the four memory cycles k+12 to k+15, which is three host cycles after the command.
- R8: host_tick_o is high in exactly one of every four memory cycles, and host_rvalid_o and host_rdata_o change only at host edges.
- R9: Commands issued on consecutive host cycles are all served. Back-to-back writes give two separate two-beat bursts, and back-to-back reads give eight consecutive valid cycles with each burst in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock (4x host clock) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_done_i | input | 1 | DDR3 initialization complete; gates host commands |
| host_tick_o | output | 1 | High in the memory cycle that ends at a host edge |
| host_cmd_i | input | 3 | Host command code |
| host_ba_i | input | 2 | Host bank select |
| host_addr_i | input | 14 | Host row/column address |
| host_wdata_i | input | 32 | Host write burst, first word in [15:0] |
| host_wmask_i | input | 4 | Host byte masks, 1 = masked |
| host_rdata_o | output | 32 | Host read burst, first word in [15:0] |
| host_rvalid_o | output | 1 | Host read data valid |
| mem_cmd_o | output | 3 | DDR3 command code |
| mem_ba_o | output | 3 | DDR3 bank address |
| mem_addr_o | output | 14 | DDR3 address |
| mem_wdata_o | output | 16 | DDR3 write bytes, first beat in [7:0] |
| mem_wmask_o | output | 2 | DDR3 byte masks |
| mem_wvalid_o | output | 1 | DDR3 write data cycle |
| mem_rdata_i | input | 16 | DDR3 read bytes, first beat in [7:0] |

## Verification
The hardest state to reach is two reads or two writes in flight at once. In that state the second burst's capture or launch registers load while the first burst is still being returned to the host or still leaving on the memory port. The bench reaches it by issuing commands on consecutive host edges. A bench-side DDR3 model with read latency 8 answers each RD with a distinct pattern. Per-cycle monitors log every memory command, write beat and valid host read cycle, so the latency, the order and any overlap can be compared against cycle counts after the stimulus ends.

// File: rtl/ddr_bridge_pkg.sv
package ddr_bridge_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;
endpackage

// File: rtl/bridge_phase.sv
module bridge_phase #(
  parameter int RATIO = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(RATIO - 1);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (phase_q == PH_LAST) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign tick_o = (phase_q == PH_LAST);
endmodule

// File: rtl/bridge_cmd.sv
module bridge_cmd
  import ddr_bridge_pkg::*;
#(
  parameter int HBA_W  = 2,
  parameter int MBA_W  = 3,
  parameter int ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              init_done_i,
  input  logic [2:0]        host_cmd_i,
  input  logic [HBA_W-1:0]  host_ba_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [2:0]        mem_cmd_o,
  output logic [MBA_W-1:0]  mem_ba_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              rd_go_o,
  output logic              wr_go_o
);
  localparam int PAD_W = MBA_W - HBA_W;

  cmd_e             hcmd;
  logic             legal;
  logic             accept;
  logic [MBA_W-1:0] ba_ext;

  // upper DDR3 bank bits tied low
  generate
    if (PAD_W > 0) begin : g_pad
      assign ba_ext = {{PAD_W{1'b0}}, host_ba_i};
    end else begin : g_nopad
      assign ba_ext = host_ba_i[MBA_W-1:0];
    end
  endgenerate

  always_comb begin
    hcmd    = cmd_e'(host_cmd_i);
    legal   = hcmd inside {CMD_ACT, CMD_RD, CMD_WR, CMD_PRE, CMD_REF};
    accept  = tick_i && init_done_i && legal;
    rd_go_o = accept && (hcmd == CMD_RD);
    wr_go_o = accept && (hcmd == CMD_WR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_cmd_o  <= CMD_NOP;
      mem_ba_o   <= '0;
      mem_addr_o <= '0;
    end else if (accept) begin
      mem_cmd_o  <= host_cmd_i;
      mem_ba_o   <= ba_ext;
      mem_addr_o <= host_addr_i;
    end else begin
      mem_cmd_o  <= CMD_NOP;
    end
  end
endmodule

// File: rtl/bridge_wr.sv
module bridge_wr #(
  parameter int MEM_W = 8,
  parameter int CWL   = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               wr_go_i,
  input  logic [4*MEM_W-1:0] host_wdata_i,
  input  logic [3:0]         host_wmask_i,
  output logic [2*MEM_W-1:0] mem_wdata_o,
  output logic [1:0]         mem_wmask_o,
  output logic               mem_wvalid_o
);
  localparam int BEAT_W = 2 * MEM_W;
  localparam int NWORD  = 2;
  localparam int SH_W   = CWL + NWORD - 1;

  logic [SH_W-1:0]         wsh_q;
  logic                    pend_q;
  logic [NWORD*BEAT_W-1:0] wbuf_q;
  logic [2*NWORD-1:0]      mbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wsh_q        <= '0;
      pend_q       <= 1'b0;
      wbuf_q       <= '0;
      mbuf_q       <= '0;
      mem_wdata_o  <= '0;
      mem_wmask_o  <= '0;
      mem_wvalid_o <= 1'b0;
    end else begin
      wsh_q <= {wsh_q[SH_W-2:0], wr_go_i};
      // data follows the command by one host cycle
      if (tick_i) begin
        pend_q <= wr_go_i;
        if (pend_q) begin
          wbuf_q <= host_wdata_i;
          mbuf_q <= host_wmask_i;
        end
      end
      mem_wvalid_o <= 1'b0;
      mem_wdata_o  <= '0;
      mem_wmask_o  <= '0;
      for (int i = 0; i < NWORD; i++) begin
        if (wsh_q[CWL-1+i]) begin
          mem_wvalid_o <= 1'b1;
          mem_wdata_o  <= wbuf_q[i*BEAT_W +: BEAT_W];
          mem_wmask_o  <= mbuf_q[2*i +: 2];
        end
      end
    end
  end
endmodule

// File: rtl/bridge_rd.sv
module bridge_rd #(
  parameter int MEM_W  = 8,
  parameter int CL_MEM = 8,
  parameter int HLAT   = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rd_go_i,
  input  logic [2*MEM_W-1:0] mem_rdata_i,
  output logic [4*MEM_W-1:0] host_rdata_o,
  output logic               host_rvalid_o
);
  localparam int BEAT_W = 2 * MEM_W;
  localparam int NWORD  = 2;

  logic [HLAT-1:0]         rsh_q;
  logic [NWORD*BEAT_W-1:0] rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsh_q         <= '0;
      rbuf_q        <= '0;
      host_rdata_o  <= '0;
      host_rvalid_o <= 1'b0;
    end else begin
      rsh_q <= {rsh_q[HLAT-2:0], rd_go_i};
      for (int i = 0; i < NWORD; i++) begin
        if (rsh_q[CL_MEM+i]) rbuf_q[i*BEAT_W +: BEAT_W] <= mem_rdata_i;
      end
      // host-side outputs move only on host edges
      if (tick_i) begin
        host_rvalid_o <= rsh_q[HLAT-1];
        if (rsh_q[HLAT-1]) host_rdata_o <= rbuf_q;
      end
    end
  end
endmodule

// File: rtl/ddr1_ddr3_bridge.sv
module ddr1_ddr3_bridge #(
  parameter int RATIO   = 4,
  parameter int MEM_W   = 8,
  parameter int HBA_W   = 2,
  parameter int MBA_W   = 3,
  parameter int ADDR_W  = 14,
  parameter int CL_HOST = 3,
  parameter int CL_MEM  = 8,
  parameter int CWL_MEM = 6,
  localparam int HOST_W  = 2 * MEM_W,
  localparam int HDATA_W = 2 * HOST_W,
  localparam int HMSK_W  = HDATA_W / MEM_W,
  localparam int MDATA_W = 2 * MEM_W,
  localparam int HLAT    = CL_HOST * RATIO
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_done_i,
  output logic               host_tick_o,
  input  logic [2:0]         host_cmd_i,
  input  logic [HBA_W-1:0]   host_ba_i,
  input  logic [ADDR_W-1:0]  host_addr_i,
  input  logic [HDATA_W-1:0] host_wdata_i,
  input  logic [HMSK_W-1:0]  host_wmask_i,
  output logic [HDATA_W-1:0] host_rdata_o,
  output logic               host_rvalid_o,
  output logic [2:0]         mem_cmd_o,
  output logic [MBA_W-1:0]   mem_ba_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [MDATA_W-1:0] mem_wdata_o,
  output logic [1:0]         mem_wmask_o,
  output logic               mem_wvalid_o,
  input  logic [MDATA_W-1:0] mem_rdata_i
);
  logic rd_go;
  logic wr_go;

  bridge_phase #(.RATIO(RATIO)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (host_tick_o)
  );

  bridge_cmd #(.HBA_W(HBA_W), .MBA_W(MBA_W), .ADDR_W(ADDR_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (host_tick_o),
    .init_done_i (init_done_i),
    .host_cmd_i  (host_cmd_i),
    .host_ba_i   (host_ba_i),
    .host_addr_i (host_addr_i),
    .mem_cmd_o   (mem_cmd_o),
    .mem_ba_o    (mem_ba_o),
    .mem_addr_o  (mem_addr_o),
    .rd_go_o     (rd_go),
    .wr_go_o     (wr_go)
  );

  bridge_wr #(.MEM_W(MEM_W), .CWL(CWL_MEM)) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (host_tick_o),
    .wr_go_i      (wr_go),
    .host_wdata_i (host_wdata_i),
    .host_wmask_i (host_wmask_i),
    .mem_wdata_o  (mem_wdata_o),
    .mem_wmask_o  (mem_wmask_o),
    .mem_wvalid_o (mem_wvalid_o)
  );

  bridge_rd #(.MEM_W(MEM_W), .CL_MEM(CL_MEM), .HLAT(HLAT)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (host_tick_o),
    .rd_go_i       (rd_go),
    .mem_rdata_i   (mem_rdata_i),
    .host_rdata_o  (host_rdata_o),
    .host_rvalid_o (host_rvalid_o)
  );
endmodule

// File: rtl/ddr_bridge_chk.sv
module ddr_bridge_chk #(
  parameter int MBA_W   = 3,
  parameter int HDATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               init_done_i,
  input logic               host_tick_o,
  input logic [2:0]         mem_cmd_o,
  input logic [MBA_W-1:0]   mem_ba_o,
  input logic               mem_wvalid_o,
  input logic               host_rvalid_o,
  input logic [HDATA_W-1:0] host_rdata_o
);
  a_r2_no_cmd_before_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |=> (mem_cmd_o == 3'd0));

  a_r3_cmd_after_host_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_tick_o |=> (mem_cmd_o == 3'd0));

  a_r4_upper_banks_unused: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ba_o[MBA_W-1] == 1'b0);

  a_r5_burst_two_beats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wvalid_o) |=> mem_wvalid_o);

  a_r5_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wvalid_o && $past(mem_wvalid_o)) |=> !mem_wvalid_o);

  a_r8_host_out_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !host_tick_o |=> ($stable(host_rvalid_o) && $stable(host_rdata_o)));

  a_r8_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_tick_o |=> !host_tick_o);
endmodule

bind ddr1_ddr3_bridge ddr_bridge_chk #(.MBA_W(MBA_W), .HDATA_W(HDATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .init_done_i   (init_done_i),
  .host_tick_o   (host_tick_o),
  .mem_cmd_o     (mem_cmd_o),
  .mem_ba_o      (mem_ba_o),
  .mem_wvalid_o  (mem_wvalid_o),
  .host_rvalid_o (host_rvalid_o),
  .host_rdata_o  (host_rdata_o)
);

// File: tb/ddr1_ddr3_bridge_test.sv
`timescale 1ns/1ps
module ddr1_ddr3_bridge_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_done_i = 1'b0;
  logic        host_tick_o;
  logic [2:0]  host_cmd_i = 3'd0;
  logic [1:0]  host_ba_i = '0;
  logic [13:0] host_addr_i = '0;
  logic [31:0] host_wdata_i = '0;
  logic [3:0]  host_wmask_i = '0;
  logic [31:0] host_rdata_o;
  logic        host_rvalid_o;
  logic [2:0]  mem_cmd_o;
  logic [2:0]  mem_ba_o;
  logic [13:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic [1:0]  mem_wmask_o;
  logic        mem_wvalid_o;
  logic [15:0] mem_rdata_i = '0;

  ddr1_ddr3_bridge uut (.*);

  always #2 clk_i = ~clk_i;

  int n_tests = 0;
  int n_fail  = 0;

  // cycle logs filled by monitors
  int cyc = 0;
  int wc[8];   int nwc = 0;
  int rc[8];   int nrc = 0;
  int bcyc[16]; logic [15:0] bdat[16]; logic [1:0] bmsk[16]; int nb = 0;
  int rvcyc[32]; logic [31:0] rvdat[32]; int nrv = 0;

  // DDR3 read model, latency 8
  logic [31:0] rd_words[4];
  int          rd_idx = 0;
  logic [31:0] pd[10];
  logic        pv[10];

  initial for (int j = 0; j < 10; j++) begin pd[j] = '0; pv[j] = 1'b0; end

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) begin
    for (int j = 9; j > 0; j--) begin pd[j] = pd[j-1]; pv[j] = pv[j-1]; end
    pv[0] = (mem_cmd_o == 3'd2);
    pd[0] = pv[0] ? rd_words[rd_idx % 4] : 32'd0;
    if (pv[0]) rd_idx++;
    mem_rdata_i = pv[8] ? pd[8][15:0] : (pv[9] ? pd[9][31:16] : 16'd0);
    if (mem_cmd_o == 3'd3 && nwc < 8) begin wc[nwc] = cyc; nwc++; end
    if (mem_cmd_o == 3'd2 && nrc < 8) begin rc[nrc] = cyc; nrc++; end
    if (mem_wvalid_o && nb < 16) begin
      bcyc[nb] = cyc; bdat[nb] = mem_wdata_o; bmsk[nb] = mem_wmask_o; nb++;
    end
    if (host_rvalid_o && nrv < 32) begin
      rvcyc[nrv] = cyc; rvdat[nrv] = host_rdata_o; nrv++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_logs();
    nwc = 0; nrc = 0; nb = 0; nrv = 0;
  endtask

  // advance to just after the next host edge
  task automatic host_step();
    @(negedge clk_i);
    while (!host_tick_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    int ticks = 0;
    @(negedge clk_i);
    chk(mem_cmd_o == 3'd0, "R1", "cmd after reset", mem_cmd_o, 0);
    chk(mem_wvalid_o == 1'b0, "R1", "wvalid after reset", mem_wvalid_o, 0);
    chk(host_rvalid_o == 1'b0, "R1", "rvalid after reset", host_rvalid_o, 0);
    for (int i = 0; i < 8; i++) begin
      if (host_tick_o) ticks++;
      @(negedge clk_i);
    end
    chk(ticks == 2, "R8", "ticks in 8 cycles", ticks, 2);
  endtask

  task automatic t_init_gate();
    host_cmd_i = 3'd1; host_ba_i = 2'd1; host_addr_i = 14'h0123;
    host_step();
    host_cmd_i = 3'd0;
    @(negedge clk_i);
    chk(mem_cmd_o == 3'd0, "R2", "cmd while not initialized", mem_cmd_o, 0);
    init_done_i = 1'b1;
  endtask

  task automatic t_cmd(input logic [2:0] c, input logic [1:0] ba,
                       input logic [13:0] a, input logic [2:0] exp_c);
    host_cmd_i = c; host_ba_i = ba; host_addr_i = a;
    host_step();
    host_cmd_i = 3'd0;
    @(negedge clk_i);
    chk(mem_cmd_o == exp_c, "R3", "forwarded cmd", mem_cmd_o, exp_c);
    if (exp_c != 3'd0) begin
      chk(mem_addr_o == a, "R3", "forwarded addr", mem_addr_o, a);
      chk(mem_ba_o == {1'b0, ba}, "R4", "remapped bank", mem_ba_o, {1'b0, ba});
    end
    @(negedge clk_i);
    chk(mem_cmd_o == 3'd0, "R3", "cmd lasts one cycle", mem_cmd_o, 0);
  endtask

  task automatic t_write(input int n, input logic [31:0] d0, input logic [31:0] d1,
                         input logic [3:0] m0, input logic [3:0] m1);
    clear_logs();
    host_cmd_i = 3'd3; host_ba_i = 2'd2; host_addr_i = 14'h0040;
    host_step();
    host_cmd_i = (n == 2) ? 3'd3 : 3'd0;
    host_wdata_i = d0; host_wmask_i = m0;
    host_step();
    host_cmd_i = 3'd0;
    host_wdata_i = d1; host_wmask_i = m1;
    for (int i = 0; i < 4; i++) host_step();
    chk(nwc == n, "R5", "WR commands seen", nwc, n);
    chk(nb == 2 * n, "R5", "write beats", nb, 2 * n);
    for (int w = 0; w < n && w < nwc && 2 * w + 1 < nb; w++) begin
      logic [31:0] d = (w == 0) ? d0 : d1;
      logic [3:0]  m = (w == 0) ? m0 : m1;
      chk(bcyc[2*w] == wc[w] + 6, "R5", "first beat cycle", bcyc[2*w] - wc[w], 6);
      chk(bcyc[2*w+1] == wc[w] + 7, "R5", "second beat cycle", bcyc[2*w+1] - wc[w], 7);
      chk(bdat[2*w] == d[15:0], "R5", "first word bytes", bdat[2*w], d[15:0]);
      chk(bdat[2*w+1] == d[31:16], "R5", "second word bytes", bdat[2*w+1], d[31:16]);
      chk(bmsk[2*w] == m[1:0], "R6", "first mask pair", bmsk[2*w], m[1:0]);
      chk(bmsk[2*w+1] == m[3:2], "R6", "second mask pair", bmsk[2*w+1], m[3:2]);
    end
    if (n == 2) chk(nb == 4, "R9", "two write bursts", nb, 4);
  endtask

  task automatic t_read(input int n, input logic [31:0] w0, input logic [31:0] w1);
    clear_logs();
    rd_idx = 0; rd_words[0] = w0; rd_words[1] = w1;
    host_cmd_i = 3'd2; host_ba_i = 2'd1; host_addr_i = 14'h0200;
    host_step();
    host_cmd_i = (n == 2) ? 3'd2 : 3'd0;
    host_step();
    host_cmd_i = 3'd0;
    for (int i = 0; i < 5; i++) host_step();
    chk(nrc == n, "R7", "RD commands seen", nrc, n);
    chk(nrv == 4 * n, "R7", "valid host cycles", nrv, 4 * n);
    if (nrc == n && nrv == 4 * n) begin
      chk(rvcyc[0] == rc[0] + 12, "R7", "read latency", rvcyc[0] - rc[0], 12);
      chk(rvdat[0] == w0, "R7", "first burst data", rvdat[0], w0);
      chk(rvdat[3] == w0, "R7", "first burst held", rvdat[3], w0);
      chk(rvcyc[4*n-1] == rc[n-1] + 15, "R7", "last valid cycle",
          rvcyc[4*n-1] - rc[n-1], 15);
      if (n == 2) begin
        chk(rvdat[4] == w1, "R9", "second burst data", rvdat[4], w1);
        chk(rvcyc[7] == rvcyc[0] + 7, "R9", "contiguous valid", rvcyc[7] - rvcyc[0], 7);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_init_gate();
    t_cmd(3'd1, 2'd3, 14'h1abc, 3'd1);
    t_cmd(3'd4, 2'd2, 14'h0400, 3'd4);
    t_cmd(3'd5, 2'd0, 14'h0000, 3'd5);
    t_cmd(3'd7, 2'd1, 14'h0055, 3'd0);
    t_write(1, 32'hA1B2C3D4, 32'h0, 4'b0110, 4'b0000);
    t_write(2, 32'h11223344, 32'h55667788, 4'b0001, 4'b1000);
    t_read(1, 32'hCAFE1234, 32'h0);
    t_read(2, 32'h0BAD0F00, 32'h600DD00D);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule